// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Run-Time Parity

This block sits in the slow serial clock domain of a larger chip. It watches one idle-high serial input, finds the start of each asynchronous frame, and samples every bit near its centre on a receive clock that runs a configurable number of cycles per bit. It rebuilds the 8-bit payload, checks the optional parity bit and the stop bit, and hands good bytes to a parallel output. That output is meant to feed a two-flop synchronizer into the faster system domain.

The oversampling ratio, whether a parity bit is present, and whether parity is even or odd all come from configuration inputs and can be changed between frames. A frame that fails its parity or stop-bit check never reaches the data output. Instead, the matching error flag pulses for one cycle, and the last good byte stays on the output.

Top module: `uart_frame_rx`

## Requirements
- R1: During and right after reset, `rx_valid`, `err_parity` and `err_stop` are 0 and `rx_data` is 0x00.
- R2: Each frame has one low start bit, then 8 data bits sent least significant bit first, then an optional parity bit, then one high stop bit. A correct frame puts its byte on `rx_data` with `rx_valid` high for exactly one clock.
- R3: When `cfg_par_en` is 1, one parity bit follows data bit 7 and comes before the stop bit. When it is 0, the stop bit follows data bit 7 and `err_parity` never asserts.
- R4: When `cfg_par_odd` is 0, parity is even: the data bits plus the parity bit hold an even number of ones. When it is 1, parity is odd and that count is odd.
- R5: A parity mismatch (with parity enabled) pulses `err_parity` for one clock, gives no `rx_valid`, and leaves `rx_data` unchanged.
- R6: A stop bit sampled low pulses `err_stop` for one clock, gives no `rx_valid`, and leaves `rx_data` unchanged.
- R7: `cfg_prescale` (6 bits) sets the bit period in receive clocks. The values 8, 16 and 32 are supported. Bit k of a frame is sampled at clocks prescale/2-1, prescale/2 and prescale/2+1, counted from the first clock on which the start bit is seen low.
- R8: Each bit's value is the majority of its three samples. A line upset that lasts one clock at the centre sample does not change the received byte.
- R9: A frame begins only on a high-to-low transition of the line. If the start bit votes high at mid-bit, the frame is abandoned: no `rx_valid`, no error flag, and `rx_data` is unchanged.
- R10: `rx_valid` is never high at the same time as either error flag. `rx_data` changes only in a cycle where `rx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive (oversampling) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_line | input | 1 | Serial input, idle high |
| cfg_par_en | input | 1 | 1: a parity bit is expected |
| cfg_par_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_prescale | input | 6 | Receive clocks per bit |
| rx_data | output | 8 | Last correctly received byte |
| rx_valid | output | 1 | One-clock strobe for a new byte |
| err_parity | output | 1 | One-clock parity error pulse |
| err_stop | output | 1 | One-clock stop-bit error pulse |

## Verification
The bench covers all three supported prescales and both parity senses. It also sends frames with the parity bit inverted, the stop bit low, or both; a design that wrote the byte out anyway would overwrite `rx_data`, and one that read the parity sense backwards would flag good frames. A one-clock upset at the centre of a data bit catches a receiver that trusts a single sample, because the byte would come out with that bit flipped. A three-clock low pulse at idle catches a receiver that commits to the start too early: it would shift in a phantom byte or raise a stop error. A parity-disabled frame that carries no parity bit catches a receiver that always expects nine bits, because it would read the stop bit as parity and then misframe.

// File: rtl/urx_pkg.sv
`timescale 1ns/1ps
package urx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } urx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/urx_bit_timer.sv
`timescale 1ns/1ps
module urx_bit_timer #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick_a,
  output logic             tick_b,
  output logic             tick_vote,
  output logic             bit_end
);

  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] half, half_m1, half_p1, last;

  always_comb begin
    half    = prescale >> 1;
    half_m1 = half - PRE_W'(1);
    half_p1 = half + PRE_W'(1);
    last    = prescale - PRE_W'(1);
  end

  always_comb begin
    if (start)
      cnt_d = PRE_W'(1);
    else if (run)
      cnt_d = (cnt_q == last) ? '0 : cnt_q + PRE_W'(1);
    else
      cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    tick_a    = run && (cnt_q == half_m1);
    tick_b    = run && (cnt_q == half);
    tick_vote = run && (cnt_q == half_p1);
    bit_end   = run && (cnt_q == last);
  end

  // R7: the counter never leaves the bit period while the prescale is steady
  p_cnt_in_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(prescale) && prescale >= PRE_W'(8)) |=> (cnt_q < prescale));

  // R7: the three sample points come in order on consecutive clocks
  p_sample_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_a && !start) |=> (tick_b || !run));

endmodule

// File: rtl/urx_vote.sv
`timescale 1ns/1ps
module urx_vote (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic take_a,
  input  logic take_b,
  output logic vote
);
  import urx_pkg::*;

  logic smp_a_q, smp_b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_a_q <= 1'b1;
      smp_b_q <= 1'b1;
    end else begin
      if (take_a) smp_a_q <= line;
      if (take_b) smp_b_q <= line;
    end
  end

  always_comb vote = maj3(smp_a_q, smp_b_q, line);

endmodule

// File: rtl/urx_frame_ctrl.sv
`timescale 1ns/1ps
module urx_frame_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              vote,
  input  logic              tick_vote,
  input  logic              bit_end,
  output logic              start,
  output logic              run,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              perr_o,
  output logic              serr_o
);
  import urx_pkg::*;

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  urx_state_e        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              pb_q, pb_d;
  logic              line_q;
  logic              valid_q, valid_d;
  logic              perr_q, perr_d;
  logic              serr_q, serr_d;
  logic              fall;
  logic              par_bad;

  always_comb begin
    fall    = line_q & ~rx_line;
    par_bad = par_en && ((^sh_q ^ pb_q) != par_odd);
    run     = (st_q != ST_IDLE);
  end

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    pb_d    = pb_q;
    data_d  = data_q;
    valid_d = 1'b0;
    perr_d  = 1'b0;
    serr_d  = 1'b0;
    start   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (fall) begin
          start = 1'b1;
          st_d  = ST_START;
        end
      end
      ST_START: begin
        if (tick_vote && vote) begin
          st_d = ST_IDLE;
        end else if (bit_end) begin
          st_d  = ST_DATA;
          idx_d = '0;
        end
      end
      ST_DATA: begin
        if (tick_vote) sh_d = {vote, sh_q[DATA_W-1:1]};
        if (bit_end) begin
          if (idx_q == LAST_IDX) st_d = par_en ? ST_PAR : ST_STOP;
          else                   idx_d = idx_q + IDX_W'(1);
        end
      end
      ST_PAR: begin
        if (tick_vote) pb_d = vote;
        if (bit_end)   st_d = ST_STOP;
      end
      ST_STOP: begin
        if (tick_vote) begin
          perr_d = par_bad;
          serr_d = ~vote;
          if (!par_bad && vote) begin
            valid_d = 1'b1;
            data_d  = sh_q;
          end
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      sh_q    <= '0;
      pb_q    <= 1'b0;
      data_q  <= '0;
      line_q  <= 1'b1;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      serr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      pb_q    <= pb_d;
      data_q  <= data_d;
      line_q  <= rx_line;
      valid_q <= valid_d;
      perr_q  <= perr_d;
      serr_q  <= serr_d;
    end
  end

  always_comb begin
    data_o  = data_q;
    valid_o = valid_q;
    perr_o  = perr_q;
    serr_o  = serr_q;
  end

  // R2: the strobe lasts a single clock
  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R10: a byte is never delivered together with an error
  p_valid_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (!perr_q && !serr_q));

  // R10: the output byte moves only with the strobe
  p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> (data_q == $past(data_q)));

  // R9: a start bit that votes high sends the receiver back to idle
  p_glitch_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && tick_vote && vote) |=> (st_q == ST_IDLE && !valid_q));

  // R3: the parity bit state is only entered when parity is enabled
  p_par_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && bit_end && idx_q == LAST_IDX && !par_en) |=> (st_q == ST_STOP));

  // R9: a frame opens only from idle on a falling line
  p_start_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && st_d == ST_START) |-> (line_q && !rx_line));

endmodule

// File: rtl/uart_frame_rx.sv
`timescale 1ns/1ps
module uart_frame_rx #(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [PRE_W-1:0]  cfg_prescale,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              err_parity,
  output logic              err_stop
);

  logic start, run;
  logic tick_a, tick_b, tick_vote, bit_end;
  logic vote;

  urx_bit_timer #(.PRE_W(PRE_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .run       (run),
    .prescale  (cfg_prescale),
    .tick_a    (tick_a),
    .tick_b    (tick_b),
    .tick_vote (tick_vote),
    .bit_end   (bit_end)
  );

  urx_vote u_vote (
    .clk    (clk),
    .rst_n  (rst_n),
    .line   (rx_line),
    .take_a (tick_a),
    .take_b (tick_b),
    .vote   (vote)
  );

  urx_frame_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_line   (rx_line),
    .par_en    (cfg_par_en),
    .par_odd   (cfg_par_odd),
    .vote      (vote),
    .tick_vote (tick_vote),
    .bit_end   (bit_end),
    .start     (start),
    .run       (run),
    .data_o    (rx_data),
    .valid_o   (rx_valid),
    .perr_o    (err_parity),
    .serr_o    (err_stop)
  );

  // R3: no parity error is reported while parity is switched off
  p_no_perr_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cfg_par_en) && $stable(cfg_par_en)) |-> !err_parity);

endmodule

// File: tb/uart_frame_rx_bench.sv
`timescale 1ns/1ps
module uart_frame_rx_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_line;
  logic       cfg_par_en;
  logic       cfg_par_odd;
  logic [5:0] cfg_prescale;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       err_parity;
  logic       err_stop;

  always #4 clk = ~clk;

  uart_frame_rx u_uart_frame_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_line      (rx_line),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_odd  (cfg_par_odd),
    .cfg_prescale (cfg_prescale),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .err_parity   (err_parity),
    .err_stop     (err_stop)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // pulse counters, sampled on the falling edge
  int   n_valid = 0, n_perr = 0, n_serr = 0, n_double = 0, n_overlap = 0;
  logic prev_valid = 1'b0;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (rx_valid) n_valid++;
      if (err_parity) n_perr++;
      if (err_stop) n_serr++;
      if (rx_valid && prev_valid) n_double++;
      if (rx_valid && (err_parity || err_stop)) n_overlap++;
      prev_valid = rx_valid;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drives one frame; upset_bit selects a bit (0 start, 1..8 data) whose centre clock is inverted
  task automatic send_frame(input logic [7:0] d, input logic pen, input logic podd,
                            input logic [5:0] pre, input logic bad_par, input logic bad_stop,
                            input int upset_bit);
    logic bits [11];
    int nb;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[i+1] = d[i];
    nb = 9;
    if (pen) begin
      bits[nb] = (^d) ^ podd ^ bad_par;
      nb++;
    end
    bits[nb] = ~bad_stop;
    nb++;
    cfg_par_en   = pen;
    cfg_par_odd  = podd;
    cfg_prescale = pre;
    for (int b = 0; b < nb; b++) begin
      for (int c = 0; c < int'(pre); c++) begin
        rx_line = (b == upset_bit && c == int'(pre) / 2) ? ~bits[b] : bits[b];
        @(negedge clk);
      end
    end
    rx_line = 1'b1;
    idle(2 * int'(pre));
  endtask

  typedef struct packed {
    logic [7:0] data;
    logic       pen;
    logic       podd;
    logic [5:0] pre;
    logic       bad_par;
    logic       bad_stop;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'hA5, 1'b1, 1'b0, 6'd32, 1'b0, 1'b0},
    '{8'h3C, 1'b1, 1'b1, 6'd16, 1'b0, 1'b0},
    '{8'h81, 1'b0, 1'b0, 6'd8,  1'b0, 1'b0},
    '{8'hFF, 1'b1, 1'b0, 6'd32, 1'b1, 1'b0},
    '{8'h00, 1'b1, 1'b1, 6'd16, 1'b0, 1'b1},
    '{8'h5A, 1'b0, 1'b1, 6'd32, 1'b1, 1'b0},
    '{8'hC3, 1'b1, 1'b1, 6'd8,  1'b1, 1'b1},
    '{8'h7E, 1'b1, 1'b0, 6'd16, 1'b0, 1'b0}
  };

  logic [7:0] good_data;

  task automatic run_frame(input string req, input vec_t v, input int upset_bit);
    int v0, p0, s0;
    logic exp_perr, exp_serr, exp_ok;
    v0 = n_valid; p0 = n_perr; s0 = n_serr;
    send_frame(v.data, v.pen, v.podd, v.pre, v.bad_par, v.bad_stop, upset_bit);
    exp_perr = v.pen & v.bad_par;
    exp_serr = v.bad_stop;
    exp_ok   = !exp_perr && !exp_serr;
    if (exp_ok) good_data = v.data;
    chk(req, "valid pulses", n_valid - v0, int'(exp_ok));
    chk(req, "parity err pulses", n_perr - p0, int'(exp_perr));
    chk(req, "stop err pulses", n_serr - s0, int'(exp_serr));
    chk(req, "rx_data", int'(rx_data), int'(good_data));
  endtask

  initial begin
    rst_n        = 1'b0;
    rx_line      = 1'b1;
    cfg_par_en   = 1'b1;
    cfg_par_odd  = 1'b0;
    cfg_prescale = 6'd32;
    good_data    = 8'h00;
    idle(3);
    // R1: outputs during reset
    chk("R1", "rx_valid in reset", int'(rx_valid), 0);
    chk("R1", "err_parity in reset", int'(err_parity), 0);
    chk("R1", "err_stop in reset", int'(err_stop), 0);
    chk("R1", "rx_data in reset", int'(rx_data), 0);
    rst_n = 1'b1;
    idle(4);
    chk("R1", "rx_valid after reset", int'(rx_valid), 0);

    // R2 R3 R4 R5 R6 R7: table of frames across prescales and parity settings
    for (int i = 0; i < 8; i++) begin
      string tag;
      if (VECS[i].bad_stop)                   tag = "R6";
      else if (VECS[i].pen && VECS[i].bad_par) tag = "R5";
      else if (!VECS[i].pen)                  tag = "R3";
      else if (VECS[i].podd)                  tag = "R4";
      else                                    tag = "R2/R7";
      run_frame(tag, VECS[i], -1);
    end

    // R8: one-clock upset at the centre of data bits 2 and 7
    run_frame("R8", '{8'h96, 1'b1, 1'b1, 6'd16, 1'b0, 1'b0}, 3);
    run_frame("R8", '{8'h4B, 1'b0, 1'b0, 6'd32, 1'b0, 1'b0}, 8);
    // R8: upset of the start bit centre is outvoted as well
    run_frame("R8", '{8'h2D, 1'b1, 1'b0, 6'd8,  1'b0, 1'b0}, 0);

    // R9: short low pulse at idle is dropped
    begin
      int v0, p0, s0;
      v0 = n_valid; p0 = n_perr; s0 = n_serr;
      cfg_prescale = 6'd16;
      rx_line = 1'b0;
      idle(3);
      rx_line = 1'b1;
      idle(200);
      chk("R9", "valid after glitch", n_valid - v0, 0);
      chk("R9", "errors after glitch", (n_perr - p0) + (n_serr - s0), 0);
      chk("R9", "rx_data after glitch", int'(rx_data), int'(good_data));
    end
    // R9: receiver recovers for the next real frame
    run_frame("R9", '{8'hE1, 1'b1, 1'b0, 6'd8, 1'b0, 1'b0}, -1);

    // R10: strobe width and exclusivity over the whole run
    chk("R10", "back-to-back valid", n_double, 0);
    chk("R10", "valid with error", n_overlap, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule